// File: doc/BRIEF.md
# Serial Controller Register Bank with Baud Divisor

This block is the host-facing register bank of a byte-oriented asynchronous serial controller. A host picks one of eight byte offsets with a 3-bit address and issues single-cycle reads or writes. The bank holds:

- the data port to the transmitter and from the receiver,
- the interrupt-enable mask and the modem-control byte,
- the line-control byte and the line status,
- a scratch byte,
- a 16-bit baud divisor.

Setting the top bit of line control swaps the first two offsets over to the low and high halves of the divisor.

The bank turns line control into framing outputs for the serial shifters: word length, stop bits, parity enable, parity sense and break. It also reports whether the divisor is usable. The framing outputs are only refreshed while the divisor is non-zero. A zero divisor therefore freezes the last good framing.

The transmitter, receiver, baud generator and interrupt arbitration sit outside the block. They connect through single-cycle strobes:

- a transmit strobe with its byte,
- a receive strobe with its byte and a busy flag,
- a line-break event input,
- a pulse whenever the break bit is changed.

Top module: `uart_regbank`

## Requirements
- R1: After reset, offset 5 reads 0x60, offset 2 reads 0x01, `div_valid` is 0, and the framing outputs are 5-bit words, one stop bit and no parity.
- R2: While line-control bit 7 is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. A write to offset 0 then produces no transmit strobe.
- R3: While line-control bit 7 is 0, a write to offset 0 raises `tx_strobe` for exactly one cycle after the write edge, with `tx_byte` equal to the written byte.
- R4: While line-control bit 7 is 0, a read of offset 0 returns the held receive byte. After that read edge, line-status bit 0 (data ready) and bit 4 (break seen) are both 0.
- R5: A write to offset 1 (bit 7 clear) keeps only bits 3:0, and offset 1 reads with bits 7:4 zero. A write to offset 4 keeps only bits 4:0, and offset 4 reads with bits 7:5 zero.
- R6: With a non-zero divisor, after a line-control write, the framing outputs follow the written line-control byte:
  - `word_len` = bits 1:0 + 5,
  - `two_stop` = bit 2,
  - `parity_en` = bit 3,
  - `parity_even` = bit 4.
- R7: `div_valid` is 1 exactly when the divisor is non-zero. While the divisor is zero the framing outputs keep their last value.
- R8: Offset 7 reads back the last byte written to it. Writes to offsets 2, 5 and 6 change nothing. Offset 2 always reads 0x01 and offset 6 reads 0x00.
- R9: `break_out` equals line-control bit 6. `break_change` pulses for one cycle after a line-control write only when the written bit 6 differs from the stored bit 6.
- R10: `rx_busy` equals the data-ready flag. A receive strobe while data ready is 0 loads `rx_byte` and sets data ready. A strobe while data ready is 1 is refused and leaves the held byte unchanged.
- R11: Offset 5 reads {0, 1, 1, break seen, 000, data ready}. A `line_break` pulse sets bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, side effects at the clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed offset, valid in the same cycle |
| tx_strobe | output | 1 | One-cycle pulse: byte handed to transmitter |
| tx_byte | output | 8 | Byte handed to transmitter |
| rx_strobe | input | 1 | Receiver offers a byte |
| rx_byte | input | 8 | Byte offered by the receiver |
| rx_busy | output | 1 | Holding byte not yet read; strobes are refused |
| line_break | input | 1 | Break condition seen on the line |
| word_len | output | 4 | Data bits per character, 5 to 8 |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity bit present |
| parity_even | output | 1 | Even parity when set, odd when clear |
| break_out | output | 1 | Force the line to the break level |
| break_change | output | 1 | One-cycle pulse when the break bit changes |
| divisor | output | 16 | Baud divisor; line rate is 115200 / divisor |
| div_valid | output | 1 | Divisor is non-zero |
| int_enable | output | 4 | Stored interrupt-enable mask |
| modem_ctrl | output | 5 | Stored modem-control bits |

## Verification
The results fall into three groups by when they are due:

- **Same cycle:** read data depends only on the address and the stored state, so it is due in the cycle the read is presented.
- **After the write edge:** the transmit strobe, the break-change pulse, the divisor, the stored masks and the framing outputs all change at the clock edge that takes the write. They are valid for the whole following cycle.
- **After the access edge:** the clearing of data-ready and break-seen by a data read, and the loading by a receive strobe, become visible only after that edge. `rx_busy` reflects the state before that edge.

The bench drives inputs on the falling edge. It checks read data and busy one time unit later, before the rising edge. It checks every edge-registered result on the falling edge after the access.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_IID     = 3'd2,
    OFS_LCTL    = 3'd3,
    OFS_MCTL    = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } ofs_e;

  // line-control bit positions
  localparam int LC_LEN_LO = 0;
  localparam int LC_STOP   = 2;
  localparam int LC_PAREN  = 3;
  localparam int LC_PEVEN  = 4;
  localparam int LC_BRK    = 6;
  localparam int LC_DLAB   = 7;

  typedef struct packed {
    logic [3:0] word_len;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
  } line_cfg_t;

  function automatic line_cfg_t lctl_decode(input logic [DATA_W-1:0] v);
    line_cfg_t c;
    c.word_len = {2'b00, v[LC_LEN_LO+1:LC_LEN_LO]} + 4'd5;
    c.two_stop = v[LC_STOP];
    c.par_en   = v[LC_PAREN];
    c.par_even = v[LC_PEVEN];
    return c;
  endfunction

endpackage

// File: rtl/uart_line_cfg.sv
module uart_line_cfg
  import uart_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] lctl_nxt,
  input  logic              div_ok_nxt,
  output line_cfg_t         cfg_q
);

  line_cfg_t cfg_d;
  logic      cfg_en;

  always_comb begin
    cfg_en = div_ok_nxt;
    cfg_d  = lctl_decode(lctl_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= lctl_decode('0);
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              line_break,
  input  logic              rd_clear,
  output logic [DATA_W-1:0] rx_data_q,
  output logic              ready_q,
  output logic              brk_seen_q
);

  logic [DATA_W-1:0] rx_data_d;
  logic              ready_d;
  logic              brk_seen_d;
  logic              load_en;

  always_comb begin
    load_en    = rx_strobe && !ready_q;
    rx_data_d  = rx_data_q;
    ready_d    = ready_q;
    brk_seen_d = brk_seen_q;
    if (rd_clear) begin
      ready_d    = 1'b0;
      brk_seen_d = 1'b0;
    end
    if (load_en) begin
      rx_data_d = rx_byte;
      ready_d   = 1'b1;
    end
    if (line_break) begin
      brk_seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_q  <= '0;
      ready_q    <= 1'b0;
      brk_seen_q <= 1'b0;
    end else begin
      rx_data_q  <= rx_data_d;
      ready_q    <= ready_d;
      brk_seen_q <= brk_seen_d;
    end
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int          IEN_W    = 4,
  parameter int          MCTL_W   = 5,
  parameter int          SYNC_LEN = 2,
  parameter logic [7:0]  IID_IDLE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        tx_strobe,
  output logic [7:0]  tx_byte,
  input  logic        rx_strobe,
  input  logic [7:0]  rx_byte,
  output logic        rx_busy,
  input  logic        line_break,
  output logic [3:0]  word_len,
  output logic        two_stop,
  output logic        parity_en,
  output logic        parity_even,
  output logic        break_out,
  output logic        break_change,
  output logic [15:0] divisor,
  output logic        div_valid,
  output logic [3:0]  int_enable,
  output logic [4:0]  modem_ctrl
);

  localparam int DIV_W = 2 * DATA_W;

  // reset: asserted asynchronously, released after SYNC_LEN clocks
  logic [SYNC_LEN-1:0] rst_pipe_q;
  logic                rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_LEN-1];

  // register state
  logic [DATA_W-1:0] lctl_q, lctl_d;
  logic [IEN_W-1:0]  ien_q, ien_d;
  logic [MCTL_W-1:0] mctl_q, mctl_d;
  logic [DATA_W-1:0] scr_q, scr_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DATA_W-1:0] txb_q, txb_d;
  logic              txgo_q, txgo_d;
  logic              brkchg_q, brkchg_d;

  logic              dlab;
  logic              rd_clear;
  ofs_e              ofs;
  logic [DATA_W-1:0] rx_data;
  logic              rx_ready;
  logic              rx_brk;
  line_cfg_t         cfg;

  assign dlab     = lctl_q[LC_DLAB];
  assign ofs      = ofs_e'(host_addr);
  assign rd_clear = host_rd && (ofs == OFS_DATA) && !dlab;

  // next-state for host writes
  always_comb begin
    lctl_d   = lctl_q;
    ien_d    = ien_q;
    mctl_d   = mctl_q;
    scr_d    = scr_q;
    div_d    = div_q;
    txb_d    = txb_q;
    txgo_d   = 1'b0;
    brkchg_d = 1'b0;
    if (host_wr) begin
      unique case (ofs)
        OFS_DATA: begin
          if (dlab) begin
            div_d[DATA_W-1:0] = host_wdata;
          end else begin
            txb_d  = host_wdata;
            txgo_d = 1'b1;
          end
        end
        OFS_IEN: begin
          if (dlab) div_d[DIV_W-1:DATA_W] = host_wdata;
          else      ien_d = host_wdata[IEN_W-1:0];
        end
        OFS_LCTL: begin
          lctl_d   = host_wdata;
          brkchg_d = host_wdata[LC_BRK] ^ lctl_q[LC_BRK];
        end
        OFS_MCTL:    mctl_d = host_wdata[MCTL_W-1:0];
        OFS_SCRATCH: scr_d  = host_wdata;
        default: ;  // identification, status and modem-status are read only
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lctl_q   <= '0;
      ien_q    <= '0;
      mctl_q   <= '0;
      scr_q    <= '0;
      div_q    <= '0;
      txb_q    <= '0;
      txgo_q   <= 1'b0;
      brkchg_q <= 1'b0;
    end else begin
      lctl_q   <= lctl_d;
      ien_q    <= ien_d;
      mctl_q   <= mctl_d;
      scr_q    <= scr_d;
      div_q    <= div_d;
      txb_q    <= txb_d;
      txgo_q   <= txgo_d;
      brkchg_q <= brkchg_d;
    end
  end

  uart_rx_hold rx_hold_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rx_strobe  (rx_strobe),
    .rx_byte    (rx_byte),
    .line_break (line_break),
    .rd_clear   (rd_clear),
    .rx_data_q  (rx_data),
    .ready_q    (rx_ready),
    .brk_seen_q (rx_brk)
  );

  uart_line_cfg line_cfg_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lctl_nxt   (lctl_d),
    .div_ok_nxt (div_d != '0),
    .cfg_q      (cfg)
  );

  // read mux
  always_comb begin
    unique case (ofs)
      OFS_DATA:    host_rdata = dlab ? div_q[DATA_W-1:0] : rx_data;
      OFS_IEN:     host_rdata = dlab ? div_q[DIV_W-1:DATA_W]
                                     : {{(DATA_W-IEN_W){1'b0}}, ien_q};
      OFS_IID:     host_rdata = IID_IDLE;
      OFS_LCTL:    host_rdata = lctl_q;
      OFS_MCTL:    host_rdata = {{(DATA_W-MCTL_W){1'b0}}, mctl_q};
      OFS_LSTAT:   host_rdata = {1'b0, 1'b1, 1'b1, rx_brk, 3'b000, rx_ready};
      OFS_MSTAT:   host_rdata = '0;
      OFS_SCRATCH: host_rdata = scr_q;
      default:     host_rdata = '0;
    endcase
  end

  assign tx_strobe    = txgo_q;
  assign tx_byte      = txb_q;
  assign rx_busy      = rx_ready;
  assign word_len     = cfg.word_len;
  assign two_stop     = cfg.two_stop;
  assign parity_en    = cfg.par_en;
  assign parity_even  = cfg.par_even;
  assign break_out    = lctl_q[LC_BRK];
  assign break_change = brkchg_q;
  assign divisor      = div_q;
  assign div_valid    = (div_q != '0);
  assign int_enable   = ien_q;
  assign modem_ctrl   = mctl_q;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dlab,
  input logic [2:0]  host_addr,
  input logic        host_wr,
  input logic        host_rd,
  input logic [7:0]  host_rdata,
  input logic        tx_strobe,
  input logic        rx_busy,
  input logic [3:0]  word_len,
  input logic        two_stop,
  input logic        parity_en,
  input logic        parity_even,
  input logic        break_out,
  input logic        break_change,
  input logic        div_valid
);

  assert_tx_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(host_wr && host_addr == 3'd0 && !dlab));

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && !(host_rd && host_addr == 3'd0 && !dlab)) |=> rx_busy);

  assert_ien_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd1 && !dlab) |-> (host_rdata[7:4] == 4'h0));

  assert_brk_pulse_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    break_change |-> (break_out != $past(break_out)));

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !div_valid |-> $stable({word_len, two_stop, parity_en, parity_even}));

  assert_word_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_len >= 4'd5) && (word_len <= 4'd8));

endmodule

bind uart_regbank uart_regbank_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .dlab         (lctl_q[7]),
  .host_addr    (host_addr),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .host_rdata   (host_rdata),
  .tx_strobe    (tx_strobe),
  .rx_busy      (rx_busy),
  .word_len     (word_len),
  .two_stop     (two_stop),
  .parity_en    (parity_en),
  .parity_even  (parity_even),
  .break_out    (break_out),
  .break_change (break_change),
  .div_valid    (div_valid)
);

// File: tb/uart_regbank_tb_top.sv
`timescale 1ns/1ps
module uart_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  host_addr;
  logic        host_wr, host_rd;
  logic [7:0]  host_wdata, host_rdata;
  logic        tx_strobe;
  logic [7:0]  tx_byte;
  logic        rx_strobe;
  logic [7:0]  rx_byte;
  logic        rx_busy, line_break;
  logic [3:0]  word_len;
  logic        two_stop, parity_en, parity_even, break_out, break_change;
  logic [15:0] divisor;
  logic        div_valid;
  logic [3:0]  int_enable;
  logic [4:0]  modem_ctrl;

  always #2.5 clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .rx_busy(rx_busy), .line_break(line_break),
    .word_len(word_len), .two_stop(two_stop), .parity_en(parity_en),
    .parity_even(parity_even), .break_out(break_out),
    .break_change(break_change), .divisor(divisor), .div_valid(div_valid),
    .int_enable(int_enable), .modem_ctrl(modem_ctrl)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [7:0]  m_lcr, m_scr, m_rbr;
  logic [3:0]  m_ier;
  logic [4:0]  m_mcr;
  logic [15:0] m_dl;
  logic        m_dr, m_bi;
  logic [6:0]  m_cfg;

  function automatic logic [6:0] exp_cfg(input logic [7:0] v);
    return {({2'b00, v[1:0]} + 4'd5), v[2], v[3], v[4]};
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_dl[7:0] : m_rbr;
      3'd1: return m_lcr[7] ? m_dl[15:8] : {4'h0, m_ier};
      3'd2: return 8'h01;
      3'd3: return m_lcr;
      3'd4: return {3'b000, m_mcr};
      3'd5: return {3'b011, m_bi, 3'b000, m_dr};
      3'd6: return 8'h00;
      default: return m_scr;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    if (a <= 3'd1 && m_lcr[7]) return "R2";
    case (a)
      3'd0: return "R4";
      3'd1, 3'd4: return "R5";
      3'd3: return "R6";
      3'd5: return "R11";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic exp_tx, exp_brk;
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    exp_tx = 1'b0; exp_brk = 1'b0;
    case (a)
      3'd0: if (m_lcr[7]) m_dl[7:0] = d; else exp_tx = 1'b1;
      3'd1: if (m_lcr[7]) m_dl[15:8] = d; else m_ier = d[3:0];
      3'd3: begin exp_brk = d[6] ^ m_lcr[6]; m_lcr = d; end
      3'd4: m_mcr = d[4:0];
      3'd7: m_scr = d;
      default: ;
    endcase
    if (m_dl != 16'h0) m_cfg = exp_cfg(m_lcr);
    @(negedge clk);
    host_wr = 1'b0;
    check(m_lcr[7] && a == 3'd0 ? "R2" : "R3", {31'b0, tx_strobe}, {31'b0, exp_tx});
    if (exp_tx) check("R3", {24'b0, tx_byte}, {24'b0, d});
    check("R9", {30'b0, break_change, break_out}, {30'b0, exp_brk, m_lcr[6]});
    check(m_dl == 16'h0 ? "R7" : "R6",
          {25'b0, word_len, two_stop, parity_en, parity_even}, {25'b0, m_cfg});
    check("R7", {31'b0, div_valid}, {31'b0, (m_dl != 16'h0)});
    check("R2", {16'b0, divisor}, {16'b0, m_dl});
    check("R5", {23'b0, int_enable, modem_ctrl}, {23'b0, m_ier, m_mcr});
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1;
    check(read_tag(a), {24'b0, host_rdata}, {24'b0, exp_read(a)});
    if (a == 3'd0 && !m_lcr[7]) begin m_dr = 1'b0; m_bi = 1'b0; end
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk);
    rx_strobe = 1'b1; rx_byte = b;
    #1;
    check("R10", {31'b0, rx_busy}, {31'b0, m_dr});
    if (!m_dr) begin m_rbr = b; m_dr = 1'b1; end
    @(negedge clk);
    rx_strobe = 1'b0;
    check("R10", {31'b0, rx_busy}, 32'd1);
  endtask

  task automatic brk();
    @(negedge clk);
    line_break = 1'b1;
    m_bi = 1'b1;
    @(negedge clk);
    line_break = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    rx_strobe = 0; rx_byte = '0; line_break = 0;
    m_lcr = '0; m_scr = '0; m_rbr = '0; m_ier = '0; m_mcr = '0; m_dl = '0;
    m_dr = 0; m_bi = 0; m_cfg = exp_cfg(8'h00);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", {31'b0, div_valid}, 32'd0);
    check("R1", {25'b0, word_len, two_stop, parity_en, parity_even}, {25'b0, exp_cfg(8'h00)});
    check("R1", {31'b0, tx_strobe}, 32'd0);
    rd(3'd5); rd(3'd2);

    // R7 line control write with zero divisor leaves framing unchanged
    wr(3'd3, 8'h1F);
    // R2 divisor overlay
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h0C); wr(3'd1, 8'h00);
    rd(3'd0); rd(3'd1);
    // R6 decode with valid divisor
    wr(3'd3, 8'h1F);
    wr(3'd3, 8'h0A);
    // R3 transmit
    wr(3'd0, 8'hA5);
    // R10/R4/R11 receive path
    rx(8'h3C); rd(3'd5); rx(8'h77); rd(3'd0); rd(3'd5);
    brk(); rd(3'd5); rd(3'd0); rd(3'd5);
    rx(8'hE1); brk(); rd(3'd5); rd(3'd0); rd(3'd5);
    // R5 masks
    wr(3'd1, 8'hFF); rd(3'd1); wr(3'd4, 8'hFF); rd(3'd4);
    // R8 scratch and ignored offsets
    wr(3'd7, 8'h5A); wr(3'd2, 8'hFF); wr(3'd5, 8'h00); wr(3'd6, 8'hFF);
    rd(3'd7); rd(3'd2); rd(3'd5); rd(3'd6);
    // R9 break toggles
    wr(3'd3, 8'h5F); wr(3'd3, 8'h5F); wr(3'd3, 8'h1F);
    // R7 zero divisor freezes framing
    wr(3'd3, 8'h80); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd3, 8'h07); wr(3'd3, 8'h1C);
    wr(3'd3, 8'h80); wr(3'd1, 8'h01); rd(3'd1); wr(3'd3, 8'h03);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom % 8;
      if (op < 3)      wr(3'($urandom), 8'($urandom));
      else if (op < 6) rd(3'($urandom));
      else if (op == 6) rx(8'($urandom));
      else             brk();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule